// File: doc/BRIEF.md
# Directory Sharing Pattern Classifier

This block sits next to a directory coherence controller at the home node of a set of memory blocks. It only watches the controller's request stream and never steers it. Each observed request carries a kind (read miss, write miss or upgrade), the requesting processor's ID and a block index. For the same cycle, the controller also supplies the block's current sharer count and a flag that tells whether the block is in the read-shared state.

For each block the classifier keeps a small record. The record holds the last processor that took write access, with a valid bit, and a few pattern bits. From these it labels the block as migratory, producer-consumer, read-only or unknown. A performance monitor reads the label through a one-cycle query port.

Top module: `sharing_classifier`

## Requirements
- R1: After reset every block reports pattern 00 (unknown), and the query output is 00.
- R2: A block that has seen at least one read miss (req_kind 00) and no write since reset reports 11 (read-only).
- R3: A write miss (req_kind 01) or upgrade (req_kind 10) to a block ends its read-only label for good.
- R4: An upgrade while the sharer count is exactly one, from a requester other than the recorded last writer (valid), sets the block to 01 (migratory).
- R5: An upgrade clears the migratory label when the sharer count is not one, when the requester equals the last writer, or when no last writer is recorded yet.
- R6: A write miss while dir_shared is high sets producer-consumer (10) if the requester equals the valid last writer, and clears it otherwise. A write miss with dir_shared low leaves that label unchanged.
- R7: When migratory and producer-consumer are both set, the block reports 01.
- R8: Every write miss and upgrade records its requester as the block's last writer. Read misses leave the last writer unchanged.
- R9: qry_pat shows the pattern of the block given on qry_blk one cycle earlier. This includes the effect of a request to that block in the same cycle.
- R10: A request changes only its own block. A cycle with req_valid low or req_kind 11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An observed coherence request is present |
| req_kind | input | 2 | 00 read miss, 01 write miss, 10 upgrade, 11 none |
| req_id | input | ID_W | Requesting processor |
| req_blk | input | IDX_W | Index of the requested block |
| dir_sharers | input | CNT_W | Sharer count the directory holds for the block |
| dir_shared | input | 1 | Block is currently in the read-shared state |
| qry_blk | input | IDX_W | Block whose pattern is queried |
| qry_pat | output | 2 | Pattern of the queried block, one cycle later |

## Verification
The hardest case to reach is the one where the migratory and producer-consumer labels are both set on one block. Each label needs its own earlier history: a write miss from the recorded writer, then an upgrade from a different processor while the sharer count is one. A long pseudo-random stream over four blocks, four processors and small sharer counts produces these histories many times. Directed sequences build them on purpose. The stream also queries the block under update in about half of its cycles, so that the forwarding path is exercised against a reference table kept in the bench.

// File: rtl/sharing_classifier.sv
module sharing_classifier #(
  parameter int NBLK  = 16,
  parameter int ID_W  = 4,
  parameter int CNT_W = 5,
  localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [ID_W-1:0]  req_id,
  input  logic [IDX_W-1:0] req_blk,
  input  logic [CNT_W-1:0] dir_sharers,
  input  logic             dir_shared,
  input  logic [IDX_W-1:0] qry_blk,
  output logic [1:0]       qry_pat
);
  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_UP = 2'b10;

  logic [NBLK-1:0]           own_vld, mig, pc, seen, wrote;
  logic [NBLK-1:0][ID_W-1:0] own_id;

  logic            cur_vld;
  logic [ID_W-1:0] cur_own;
  logic            n_vld, n_mig, n_pc, n_seen, n_wrote;
  logic [ID_W-1:0] n_own;
  logic            act;

  assign act     = req_valid && (req_kind != 2'b11);
  assign cur_vld = own_vld[req_blk];
  assign cur_own = own_id[req_blk];

  always_comb begin
    n_vld   = cur_vld;
    n_own   = cur_own;
    n_mig   = mig[req_blk];
    n_pc    = pc[req_blk];
    n_seen  = seen[req_blk];
    n_wrote = wrote[req_blk];
    if (act) begin
      n_seen = 1'b1;
      if (req_kind == K_WR) begin
        n_wrote = 1'b1;
        if (dir_shared) n_pc = cur_vld && (cur_own == req_id);
        n_vld = 1'b1;
        n_own = req_id;
      end else if (req_kind == K_UP) begin
        n_wrote = 1'b1;
        n_mig   = (dir_sharers == CNT_W'(1)) && cur_vld && (cur_own != req_id);
        n_vld   = 1'b1;
        n_own   = req_id;
      end
    end
  end

  function automatic logic [1:0] enc(input logic m, input logic p,
                                     input logic s, input logic w);
    if (m)           return 2'b01;
    else if (p)      return 2'b10;
    else if (s && !w) return 2'b11;
    else             return 2'b00;
  endfunction

  logic       fwd;
  logic [1:0] q_next;
  assign fwd    = act && (req_blk == qry_blk);
  assign q_next = fwd ? enc(n_mig, n_pc, n_seen, n_wrote)
                      : enc(mig[qry_blk], pc[qry_blk], seen[qry_blk], wrote[qry_blk]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld <= '0;
      own_id  <= '0;
      mig     <= '0;
      pc      <= '0;
      seen    <= '0;
      wrote   <= '0;
      qry_pat <= 2'b00;
    end else begin
      qry_pat <= q_next;
      if (act) begin
        own_vld[req_blk] <= n_vld;
        own_id[req_blk]  <= n_own;
        mig[req_blk]     <= n_mig;
        pc[req_blk]      <= n_pc;
        seen[req_blk]    <= n_seen;
        wrote[req_blk]   <= n_wrote;
      end
    end
  end
endmodule

module sharing_classifier_chk #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 5,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [ID_W-1:0]  req_id,
  input logic [IDX_W-1:0] req_blk,
  input logic [CNT_W-1:0] dir_sharers,
  input logic             dir_shared,
  input logic [IDX_W-1:0] qry_blk,
  input logic [1:0]       qry_pat,
  input logic             cur_vld,
  input logic [ID_W-1:0]  cur_own
);
  logic same;
  assign same = req_valid && (req_blk == qry_blk);

  AST_RESET_UNKNOWN: assert property (@(posedge clk) $rose(rst_n) |-> qry_pat == 2'b00); // R1
  AST_WRITE_ENDS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    same && (req_kind == 2'b01 || req_kind == 2'b10) |=> qry_pat != 2'b11); // R3
  AST_MIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    same && req_kind == 2'b10 && dir_sharers == CNT_W'(1) && cur_vld && cur_own != req_id
    |=> qry_pat == 2'b01); // R4
  AST_MIG_CLEAR_SHARERS: assert property (@(posedge clk) disable iff (!rst_n)
    same && req_kind == 2'b10 && dir_sharers != CNT_W'(1) |=> qry_pat != 2'b01); // R5
  AST_PC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    same && req_kind == 2'b01 && dir_shared && cur_vld && cur_own == req_id
    |=> (qry_pat == 2'b01 || qry_pat == 2'b10)); // R6
  AST_READ_KEEPS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'b00 ##1 ($past(req_blk) == req_blk) |-> $stable(cur_vld) && $stable(cur_own)); // R8
endmodule

bind sharing_classifier sharing_classifier_chk #(.ID_W(ID_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_id(req_id),
  .req_blk(req_blk), .dir_sharers(dir_sharers), .dir_shared(dir_shared), .qry_blk(qry_blk),
  .qry_pat(qry_pat), .cur_vld(cur_vld), .cur_own(cur_own));

// File: tb/test_sharing_classifier.sv
`timescale 1ns/1ps
module test_sharing_classifier;
  localparam int NBLK = 4, ID_W = 2, CNT_W = 3, IDX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, dir_shared = 1'b0;
  logic [1:0] req_kind = '0, qry_pat;
  logic [ID_W-1:0] req_id = '0;
  logic [IDX_W-1:0] req_blk = '0, qry_blk = '0;
  logic [CNT_W-1:0] dir_sharers = '0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sharing_classifier #(.NBLK(NBLK), .ID_W(ID_W), .CNT_W(CNT_W)) i_sharing_classifier (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_id(req_id),
    .req_blk(req_blk), .dir_sharers(dir_sharers), .dir_shared(dir_shared),
    .qry_blk(qry_blk), .qry_pat(qry_pat));

  logic m_vld[NBLK], m_mig[NBLK], m_pc[NBLK], m_seen[NBLK], m_wr[NBLK];
  logic [ID_W-1:0] m_own[NBLK];

  function automatic logic [1:0] mpat(input int b);
    if (m_mig[b]) return 2'b01;
    if (m_pc[b]) return 2'b10;
    if (m_seen[b] && !m_wr[b]) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(input logic [1:0] exp, input string req);
    checks++;
    if (qry_pat !== exp) begin
      fails++;
      $display("FAIL %s: qry_pat=%b expected=%b", req, qry_pat, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] k, input int id, input int b,
                      input int sh, input logic shd, input int q, input string req);
    @(negedge clk);
    req_valid = v; req_kind = k; req_id = ID_W'(id); req_blk = IDX_W'(b);
    dir_sharers = CNT_W'(sh); dir_shared = shd; qry_blk = IDX_W'(q);
    @(negedge clk);
    if (v && k != 2'b11) begin
      m_seen[b] = 1'b1;
      if (k == 2'b01) begin
        m_wr[b] = 1'b1;
        if (shd) m_pc[b] = m_vld[b] && m_own[b] == ID_W'(id);
        m_vld[b] = 1'b1; m_own[b] = ID_W'(id);
      end else if (k == 2'b10) begin
        m_wr[b] = 1'b1;
        m_mig[b] = (sh == 1) && m_vld[b] && m_own[b] != ID_W'(id);
        m_vld[b] = 1'b1; m_own[b] = ID_W'(id);
      end
    end
    check(mpat(q), req);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int b = 0; b < NBLK; b++) begin
      m_vld[b] = 0; m_mig[b] = 0; m_pc[b] = 0; m_seen[b] = 0; m_wr[b] = 0; m_own[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    for (int b = 0; b < NBLK; b++) step(0, 2'b00, 0, 0, 0, 0, b, "R1");
    step(1, 2'b00, 1, 2, 2, 1, 2, "R2");
    step(1, 2'b00, 3, 2, 3, 1, 2, "R2");
    step(1, 2'b11, 0, 2, 1, 0, 2, "R10");
    step(1, 2'b00, 0, 3, 1, 1, 2, "R10");
    step(1, 2'b01, 1, 2, 1, 0, 2, "R3");
    step(1, 2'b00, 1, 2, 1, 1, 2, "R3");
    step(1, 2'b10, 2, 2, 1, 1, 2, "R4");
    step(1, 2'b00, 3, 2, 2, 1, 2, "R8");
    step(1, 2'b10, 2, 2, 1, 1, 2, "R5");
    step(1, 2'b10, 0, 2, 1, 1, 2, "R4");
    step(1, 2'b10, 1, 2, 2, 1, 2, "R5");
    step(1, 2'b10, 3, 1, 1, 1, 1, "R5");
    step(1, 2'b01, 0, 0, 2, 1, 0, "R6");
    step(1, 2'b01, 0, 0, 2, 1, 0, "R6");
    step(1, 2'b01, 0, 0, 2, 0, 0, "R6");
    step(1, 2'b10, 1, 0, 1, 1, 0, "R7");
    step(1, 2'b10, 1, 0, 1, 1, 0, "R7");
    step(1, 2'b01, 2, 0, 2, 1, 0, "R6");
    step(0, 2'b10, 3, 0, 1, 1, 0, "R10");
    do_reset();
    step(0, 2'b00, 0, 0, 0, 0, 0, "R1");
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        logic [15:0] r;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        r = lf;
        step(r[0] | r[1], r[3:2], int'(r[5:4]), int'(r[7:6]), int'(r[9:8]), r[10],
             r[11] ? int'(r[7:6]) : int'(r[13:12]), "R9");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule